// File: doc/BRIEF.md
# Six-Channel Servo Frame Sequencer

This block is the timing and control state machine that lets one shared fuzzy-logic processor serve several servo joints in turn. Each joint is handled in a fixed chain: a converter-reset interval at the start of the frame, a single pulse that samples the joint's position and latches its setpoint, a wait for the ADC side to report that the sample is ready, a single start pulse to the processor for that joint, and a wait for the DAC side to report that the result has been written. Only then does the next joint begin.

Joints are visited in ascending order of address. After the last joint a one-clock frame-complete pulse is raised. The sequencer then goes back to idle, or it begins a new frame at once if start is still asserted. With the usual budget of 10 µs of conversion plus 32.7 µs of processing per joint at a 100 MHz clock, a frame of six joints takes about 256.2 µs, which gives a frame rate near 3.9 kHz. Here the converter and processor latencies are set entirely by the handshake inputs. The number of joints and the length of the reset interval are parameters.

Top module: `servo_frame_seq`

## Requirements
- R1: While rst_n is low, and in idle after reset, every output is low and ch_addr_o is 0.
- R2: A high start_i sampled in idle raises conv_rst_o from the next cycle for exactly RST_CYCLES cycles, with ch_addr_o at 0.
- R3: In the cycle after the reset interval ends, and in the cycle after each non-final channel completes, sample_o is high for exactly one cycle.
- R4: After sample_o, the sequence holds, with no output high, until adc_ready_i is sampled high. adc_ready_i has no effect in any other phase.
- R5: In the cycle after adc_ready_i is accepted, exactly one bit of fuzz_go_o is high for one cycle, and that bit is bit ch_addr_o (bit k belongs to channel k).
- R6: After the fuzz_go_o pulse, the sequence holds until dac_done_i is sampled high. dac_done_i has no effect in any other phase.
- R7: Channels are served in order 0, 1, …, NUM_CH-1. ch_addr_o rises by one when dac_done_i is accepted for a non-final channel.
- R8: When dac_done_i is accepted for channel NUM_CH-1, frame_done_o is high for exactly one cycle in the next cycle, and ch_addr_o is 0 during that cycle.
- R9: If start_i is high during the frame_done_o cycle, conv_rst_o rises in the next cycle. Otherwise the block returns to idle.
- R10: start_i has no effect while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame (sampled in idle and in the frame-complete cycle) |
| adc_ready_i | input | 1 | ADC interface reports the sample is ready |
| dac_done_i | input | 1 | DAC interface reports the result has been written |
| conv_rst_o | output | 1 | Reset to the converter interfaces at frame start |
| ch_addr_o | output | CH_W | Address of the channel being served |
| sample_o | output | 1 | Start conversion and latch setpoint for the current channel |
| fuzz_go_o | output | NUM_CH | Per-channel processor start pulse |
| frame_done_o | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The bench builds the block with NUM_CH = 6 and RST_CYCLES = 3. This selects the counted variant of the reset interval, so its exact length is checked, and it places the wrap from channel 5 back to 0 inside a 3-bit address. A behavioural model is stepped on every clock while the handshakes are driven immediately, randomly, or only after long delays. Start is also held high across frame boundaries to exercise back-to-back frames and the rule that start is ignored mid-frame.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_CLR      = 3'd1,
      ST_SAMPLE   = 3'd2,
      ST_WAIT_ADC = 3'd3,
      ST_GO       = 3'd4,
      ST_WAIT_DAC = 3'd5,
      ST_DONE     = 3'd6
   } seq_state_t;
endpackage

// File: rtl/seq_chan_ctr.sv
module seq_chan_ctr #(
   parameter int NUM_CH = 6,
   parameter int CH_W   = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv_i,
   output logic [CH_W-1:0] ch_o,
   output logic            last_o
);
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ch_o <= '0;
      else if (adv_i)
         ch_o <= (ch_o == LAST_CH) ? '0 : ch_o + 1'b1;
   end

   assign last_o = (ch_o == LAST_CH);
endmodule

// File: rtl/seq_onehot_dec.sv
module seq_onehot_dec #(
   parameter int NUM_CH = 6,
   parameter int CH_W   = 3
) (
   input  logic              en_i,
   input  logic [CH_W-1:0]   sel_i,
   output logic [NUM_CH-1:0] out_o
);
   for (genvar k = 0; k < NUM_CH; k++) begin : g_bit
      assign out_o[k] = en_i && (sel_i == CH_W'(k));
   end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
   import seq_pkg::*;
#(
   parameter int RST_CYCLES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       adc_ready_i,
   input  logic       dac_done_i,
   input  logic       last_ch_i,
   output seq_state_t state_o,
   output logic       adv_ch_o
);
   seq_state_t nxt;
   logic       clr_done;

   if (RST_CYCLES > 1) begin : g_clr_cnt
      localparam int RCW = $clog2(RST_CYCLES);
      localparam logic [RCW-1:0] CNT_LAST = RCW'(RST_CYCLES - 1);
      logic [RCW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n || state_o != ST_CLR)
            cnt <= '0;
         else
            cnt <= cnt + 1'b1;
      end
      assign clr_done = (cnt == CNT_LAST);
   end else begin : g_clr_single
      assign clr_done = 1'b1;
   end

   always_comb begin
      nxt      = state_o;
      adv_ch_o = 1'b0;
      case (state_o)
         ST_IDLE:     if (start_i) nxt = ST_CLR;
         ST_CLR:      if (clr_done) nxt = ST_SAMPLE;
         ST_SAMPLE:   nxt = ST_WAIT_ADC;
         ST_WAIT_ADC: if (adc_ready_i) nxt = ST_GO;
         ST_GO:       nxt = ST_WAIT_DAC;
         ST_WAIT_DAC: if (dac_done_i) begin
                         adv_ch_o = 1'b1;
                         nxt      = last_ch_i ? ST_DONE : ST_SAMPLE;
                      end
         ST_DONE:     nxt = start_i ? ST_CLR : ST_IDLE;
         default:     nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         state_o <= ST_IDLE;
      else
         state_o <= nxt;
   end
endmodule

// File: rtl/servo_frame_seq.sv
module servo_frame_seq
   import seq_pkg::*;
#(
   parameter int NUM_CH     = 6,
   parameter int RST_CYCLES = 2,
   localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              adc_ready_i,
   input  logic              dac_done_i,
   output logic              conv_rst_o,
   output logic [CH_W-1:0]   ch_addr_o,
   output logic              sample_o,
   output logic [NUM_CH-1:0] fuzz_go_o,
   output logic              frame_done_o
);
   if (NUM_CH < 2) begin : g_bad_ch
      $error("servo_frame_seq: NUM_CH must be at least 2");
   end
   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("servo_frame_seq: RST_CYCLES must be at least 1");
   end

   seq_state_t state;
   logic       adv_ch;
   logic       last_ch;

   seq_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .adc_ready_i (adc_ready_i),
      .dac_done_i  (dac_done_i),
      .last_ch_i   (last_ch),
      .state_o     (state),
      .adv_ch_o    (adv_ch)
   );

   seq_chan_ctr #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv_i  (adv_ch),
      .ch_o   (ch_addr_o),
      .last_o (last_ch)
   );

   seq_onehot_dec #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
      .en_i  (state == ST_GO),
      .sel_i (ch_addr_o),
      .out_o (fuzz_go_o)
   );

   assign conv_rst_o   = (state == ST_CLR);
   assign sample_o     = (state == ST_SAMPLE);
   assign frame_done_o = (state == ST_DONE);
endmodule

// File: rtl/servo_frame_seq_chk.sv
module servo_frame_seq_chk #(
   parameter int NUM_CH     = 6,
   parameter int RST_CYCLES = 2,
   localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              adc_ready_i,
   input logic              dac_done_i,
   input logic              conv_rst_o,
   input logic [CH_W-1:0]   ch_addr_o,
   input logic              sample_o,
   input logic [NUM_CH-1:0] fuzz_go_o,
   input logic              frame_done_o
);
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

   assert_clr_at_ch0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      conv_rst_o |-> (ch_addr_o == '0));

   assert_sample_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sample_o |=> !sample_o);

   assert_go_matches_ch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|fuzz_go_o) |-> (fuzz_go_o == (NUM_CH'(1) << ch_addr_o)));

   assert_go_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|fuzz_go_o) |=> (fuzz_go_o == '0));

   assert_go_after_adc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|fuzz_go_o) |-> $past(adc_ready_i));

   assert_ch_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_o && !$past(conv_rst_o)) |-> (ch_addr_o == $past(ch_addr_o) + 1'b1));

   assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |-> ($past(dac_done_i) && $past(ch_addr_o) == LAST_CH && ch_addr_o == '0));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |=> !frame_done_o);
endmodule

bind servo_frame_seq servo_frame_seq_chk #(.NUM_CH(NUM_CH), .RST_CYCLES(RST_CYCLES)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .adc_ready_i  (adc_ready_i),
   .dac_done_i   (dac_done_i),
   .conv_rst_o   (conv_rst_o),
   .ch_addr_o    (ch_addr_o),
   .sample_o     (sample_o),
   .fuzz_go_o    (fuzz_go_o),
   .frame_done_o (frame_done_o)
);

// File: tb/servo_frame_seq_bench.sv
`timescale 1ns/1ps
module servo_frame_seq_bench;
   localparam int N   = 6;
   localparam int RC  = 3;
   localparam int CW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0, adc_ready_i = 1'b0, dac_done_i = 1'b0;
   logic          conv_rst_o, sample_o, frame_done_o;
   logic [CW-1:0] ch_addr_o;
   logic [N-1:0]  fuzz_go_o;

   always #4 clk = ~clk;

   servo_frame_seq #(.NUM_CH(N), .RST_CYCLES(RC)) u_servo_frame_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .adc_ready_i(adc_ready_i),
      .dac_done_i(dac_done_i), .conv_rst_o(conv_rst_o), .ch_addr_o(ch_addr_o),
      .sample_o(sample_o), .fuzz_go_o(fuzz_go_o), .frame_done_o(frame_done_o));

   int checks = 0, errors = 0, cycles = 0;
   // model phases: 0 idle, 1 converter reset, 2 sample, 3 wait adc, 4 go, 5 wait dac, 6 frame done
   int m_ph = 0, m_prev = 0, m_cnt = 0, m_ch = 0;
   int clr_entries = 0, clr_seen = 0, frames_seen = 0, frames_exp = 0, start_ignored = 0;
   int mode = 0;          // 0 quiet, 1 fast, 2 random, 3 slow
   int start_mode = 0;    // 0 low, 1 one pulse, 2 random, 3 held high
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
      end
   endtask

   function automatic string ph_tag(input int ph, input int prev);
      case (ph)
         0: return (prev == 6) ? "R9" : "R1";
         1: return (prev == 6) ? "R9" : "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         default: return "R8";
      endcase
   endfunction

   // behavioural reference, stepped on every clock
   always @(posedge clk) begin
      m_prev <= m_ph;
      if (!rst_n) begin
         m_ph <= 0; m_cnt <= 0; m_ch <= 0;
      end else begin
         if (start_i && m_ph >= 2 && m_ph <= 5) start_ignored <= start_ignored + 1;
         case (m_ph)
            0: if (start_i) begin m_ph <= 1; m_cnt <= 0; clr_entries <= clr_entries + 1; end
            1: if (m_cnt == RC - 1) m_ph <= 2; else m_cnt <= m_cnt + 1;
            2: m_ph <= 3;
            3: if (adc_ready_i) m_ph <= 4;
            4: m_ph <= 5;
            5: if (dac_done_i) begin
                  if (m_ch == N - 1) begin m_ch <= 0; m_ph <= 6; frames_exp <= frames_exp + 1; end
                  else begin m_ch <= m_ch + 1; m_ph <= 2; end
               end
            default: if (start_i) begin m_ph <= 1; m_cnt <= 0; clr_entries <= clr_entries + 1; end
                     else m_ph <= 0;
         endcase
      end
   end

   // compare at the falling edge, then drive the next inputs
   always @(negedge clk) begin
      string t;
      int exp_go;
      cycles++;
      t = (!rst_n) ? "R1" : ph_tag(m_ph, m_prev);
      exp_go = (m_ph == 4) ? (1 << m_ch) : 0;
      chk(conv_rst_o == (m_ph == 1), (m_ph >= 2 && m_ph <= 5) ? "R10" : t, "conv_rst_o", conv_rst_o, m_ph == 1);
      chk(sample_o == (m_ph == 2), t, "sample_o", sample_o, m_ph == 2);
      chk(int'(fuzz_go_o) == exp_go, t, "fuzz_go_o", fuzz_go_o, exp_go);
      chk(frame_done_o == (m_ph == 6), t, "frame_done_o", frame_done_o, m_ph == 6);
      chk(int'(ch_addr_o) == m_ch, (!rst_n) ? "R1" : "R7", "ch_addr_o", ch_addr_o, m_ch);
      if (rst_n && conv_rst_o) clr_seen++;
      if (rst_n && frame_done_o) frames_seen++;

      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (mode)
         1: begin adc_ready_i = 1'b1; dac_done_i = 1'b1; end
         2: begin adc_ready_i = lfsr[1] & lfsr[2]; dac_done_i = lfsr[3] & lfsr[5]; end
         3: begin adc_ready_i = (lfsr[4:0] == 5'd0); dac_done_i = (lfsr[9:5] == 5'd1); end
         default: begin adc_ready_i = 1'b0; dac_done_i = 1'b0; end
      endcase
      case (start_mode)
         1: begin start_i = 1'b1; start_mode = 0; end
         2: start_i = lfsr[7];
         3: start_i = 1'b1;
         default: start_i = 1'b0;
      endcase

      if (cycles > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      wait_cycles(4);                  // R1 checked while in reset
      rst_n = 1'b1;
      wait_cycles(5);                  // R1: idle with no start
      mode = 1; start_mode = 1;        // R2, R3, R5, R7, R8: single fast frame
      wait_cycles(60);
      mode = 3; start_mode = 1;        // R4, R6: long handshake waits, inputs ignored in other phases
      wait_cycles(2500);
      mode = 2; start_mode = 2;        // R9, R10: random start and handshakes
      wait_cycles(4000);
      mode = 1; start_mode = 3;        // R9: back-to-back frames with start held high
      wait_cycles(300);
      start_mode = 0; mode = 1;
      wait_cycles(100);
      mode = 0;
      wait_cycles(5);
      chk(frames_seen == frames_exp && frames_exp > 5, "R8", "frame count", frames_seen, frames_exp);
      chk(clr_seen == RC * clr_entries, "R10", "reset-interval cycles", clr_seen, RC * clr_entries);
      chk(start_ignored > 0, "R10", "mid-frame start stimulus", start_ignored, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule